// File: doc/BRIEF.md
# Multichannel Over-Range Flag and Interrupt Unit

This block gathers one-cycle over-range strobes from every channel of a multichannel converter and reports them in one of two ways, chosen by a mode input. In stand-alone mode it drives one shared active-low flag. The flag drops in the same cycle that any channel reports an over-range. It then stays low until a fixed number of cycles pass with no new over-range. Any new over-range on any channel restarts that hold window.

In register mode the shared flag stays inactive (high) and the block acts as a small status and interrupt source. Each channel owns a sticky status bit. A mask register chooses which channels may raise the active-high interrupt. Software reads the status and the mask through a one-bit-address register port, writes the mask, and empties the status bits with a clear strobe.

The hold timer is a two-state machine:
- **TMR_IDLE**: the flag is high.
- **TMR_HOLD**: a down-counter is running and the flag is low.

Its transitions are:
- **arm**: TMR_IDLE to TMR_HOLD on any strobe.
- **rearm**: TMR_HOLD to TMR_HOLD with the counter reloaded on any strobe.
- **expire**: TMR_HOLD to TMR_IDLE when the counter reaches zero with no strobe.
- **abandon**: any state to TMR_IDLE while register mode is selected.

Top module: `overrange_reporter`

## Requirements
- R1: With `reg_mode`=0 (stand-alone), `flag_n` is 0 in the same cycle that any bit of `ovr_strobe` is 1, with no register in between.
- R2: With `reg_mode`=0, when the last strobe occurs in cycle t, `flag_n` is 0 in cycles t through t+TIMEOUT-1 and returns to 1 in cycle t+TIMEOUT.
- R3: A strobe on any channel while the flag is held low restarts the hold window, so the release is counted from the newest strobe.
- R4: Status bit i is set at the clock edge that sees `ovr_strobe[i]`=1, in either mode. It then stays set until a clear or a reset. The status is read with `reg_addr`=0, where bit i is channel i.
- R5: `stat_clr`=1 clears all status bits at the next edge. A strobe in the same cycle as a clear leaves its status bit set.
- R6: With `reg_we`=1 and `reg_addr`=1, `reg_wdata` is loaded into the mask. The mask reads back at `reg_addr`=1. A write with `reg_addr`=0 changes nothing.
- R7: With `reg_mode`=1, `irq` is 1 exactly when some channel has both its status bit and its mask bit at 1. A mask bit of 1 enables its channel.
- R8: With `reg_mode`=1, `flag_n` is 1 and the hold timer is abandoned. With `reg_mode`=0, `irq` is 0.
- R9: While `rst`=1 is seen at a clock edge, status clears to zero, the mask is set to all ones, the timer goes idle, `flag_n` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovr_strobe | input | CHANNELS | Per-channel over-range strobe, one bit per channel |
| reg_mode | input | 1 | 0 = stand-alone flag mode, 1 = register/interrupt mode |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wdata | input | CHANNELS | Register write data |
| stat_clr | input | 1 | Clears all status bits |
| flag_n | output | 1 | Shared overflow flag, active low |
| reg_rdata | output | CHANNELS | Read data of the selected register |
| irq | output | 1 | Masked interrupt, active high |

## Verification
The bench times the flag release to the exact cycle after a single strobe. It does the same after a strobe that lands mid-window. An off-by-one counter load would release a cycle early or late, and a timer that ignored retriggers would release while the later over-range was still inside its window. It also drives a clear and a strobe in the same cycle. A design that let the clear win would lose that over-range from status and interrupt. Finally, it switches modes while the flag is held, which would leave a stale low flag in register mode or a leftover hold window after returning to stand-alone mode, and it writes to the status address, which must not disturb the status or the mask.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_HOLD = 1'b1
    } tmr_state_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    localparam logic MODE_STANDALONE = 1'b0;
    localparam logic MODE_REGISTER   = 1'b1;

endpackage

// File: rtl/ovr_hold_timer.sv
module ovr_hold_timer
    import ovr_pkg::*;
#(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic any_hit,
    input  logic reg_mode,
    output logic flag_n
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT - 2);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sa_hit;

    assign sa_hit = any_hit && (reg_mode == MODE_STANDALONE);

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (reg_mode == MODE_REGISTER) begin
            state_d = TMR_IDLE;              // abandon
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    if (sa_hit) begin        // arm
                        state_d = TMR_HOLD;
                        cnt_d   = RELOAD;
                    end
                end
                TMR_HOLD: begin
                    if (sa_hit) begin        // rearm
                        cnt_d = RELOAD;
                    end else if (cnt_q == '0) begin
                        state_d = TMR_IDLE;  // expire
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        if (reg_mode == MODE_REGISTER) begin
            flag_n = 1'b1;
        end else begin
            unique case (state_q)
                TMR_IDLE: flag_n = !sa_hit;
                TMR_HOLD: flag_n = 1'b0;
                default:  flag_n = 1'b1;
            endcase
        end
    end

    // R3: any stand-alone strobe leaves the timer holding with a full count
    a_r3_rearm_full: assert property (@(posedge clk) disable iff (rst)
        sa_hit |=> (state_q == TMR_HOLD) && (cnt_q == RELOAD));

    // R2: no release while the count is still running
    a_r2_no_early_release: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_HOLD && cnt_q != '0 && reg_mode == MODE_STANDALONE)
        |=> (state_q == TMR_HOLD));

    // R8: register mode leaves the timer idle
    a_r8_abandon: assert property (@(posedge clk) disable iff (rst)
        (reg_mode == MODE_REGISTER) |=> (state_q == TMR_IDLE));

endmodule

// File: rtl/ovr_status_bank.sv
module ovr_status_bank #(
    parameter int CHANNELS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] ovr_strobe,
    input  logic                stat_clr,
    output logic [CHANNELS-1:0] status
);
    logic [CHANNELS-1:0] status_q;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[g] <= 1'b0;
            end else if (ovr_strobe[g]) begin
                status_q[g] <= 1'b1;
            end else if (stat_clr) begin
                status_q[g] <= 1'b0;
            end
        end
    end

    assign status = status_q;

    // R4: without a clear, no status bit falls
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5: a strobe during a clear still lands
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> ((status_q & $past(ovr_strobe)) == $past(ovr_strobe)));

endmodule

// File: rtl/ovr_reg_port.sv
module ovr_reg_port
    import ovr_pkg::*;
#(
    parameter int CHANNELS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic                reg_addr,
    input  logic [CHANNELS-1:0] reg_wdata,
    input  logic [CHANNELS-1:0] status,
    output logic [CHANNELS-1:0] mask,
    output logic [CHANNELS-1:0] reg_rdata
);
    logic [CHANNELS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (reg_we && reg_addr == ADDR_MASK) begin
            mask_q <= reg_wdata;
        end
    end

    assign mask      = mask_q;
    assign reg_rdata = (reg_addr == ADDR_MASK) ? mask_q : status;

    // R6: mask changes only through a write to the mask address
    a_r6_mask_write_only: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == ADDR_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/overrange_reporter.sv
module overrange_reporter
    import ovr_pkg::*;
#(
    parameter int CHANNELS = 6,
    parameter int TIMEOUT  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] ovr_strobe,
    input  logic                reg_mode,
    input  logic                reg_we,
    input  logic                reg_addr,
    input  logic [CHANNELS-1:0] reg_wdata,
    input  logic                stat_clr,
    output logic                flag_n,
    output logic [CHANNELS-1:0] reg_rdata,
    output logic                irq
);
    logic [CHANNELS-1:0] status;
    logic [CHANNELS-1:0] mask;
    logic                any_hit;

    assign any_hit = |ovr_strobe;

    ovr_hold_timer #(.TIMEOUT(TIMEOUT)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .any_hit  (any_hit),
        .reg_mode (reg_mode),
        .flag_n   (flag_n)
    );

    ovr_status_bank #(.CHANNELS(CHANNELS)) i_status (
        .clk        (clk),
        .rst        (rst),
        .ovr_strobe (ovr_strobe),
        .stat_clr   (stat_clr),
        .status     (status)
    );

    ovr_reg_port #(.CHANNELS(CHANNELS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .mask      (mask),
        .reg_rdata (reg_rdata)
    );

    assign irq = (reg_mode == MODE_REGISTER) && (|(status & mask));

    // R1: an over-range in stand-alone mode pulls the flag low at once
    a_r1_flag_immediate: assert property (@(posedge clk) disable iff (rst)
        (reg_mode == MODE_STANDALONE && any_hit) |-> !flag_n);

    // R8: the output of the inactive mode stays quiet
    a_r8_flag_idle_in_reg: assert property (@(posedge clk) disable iff (rst)
        (reg_mode == MODE_REGISTER) |-> flag_n);
    a_r8_irq_quiet_standalone: assert property (@(posedge clk) disable iff (rst)
        (reg_mode == MODE_STANDALONE) |-> !irq);

endmodule

// File: tb/test_overrange_reporter.sv
module test_overrange_reporter;
    localparam int N   = 6;
    localparam int TMO = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] ovr_strobe = '0;
    logic         reg_mode = 1'b0;
    logic         reg_we = 1'b0;
    logic         reg_addr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic         stat_clr = 1'b0;
    logic         flag_n;
    logic [N-1:0] reg_rdata;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    overrange_reporter #(.CHANNELS(N), .TIMEOUT(TMO)) i_overrange_reporter (
        .clk(clk), .rst(rst), .ovr_strobe(ovr_strobe), .reg_mode(reg_mode),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .stat_clr(stat_clr), .flag_n(flag_n), .reg_rdata(reg_rdata), .irq(irq)
    );

    // vector: {ovr[6], clr, we, addr, wdata[6], exp_status[6], exp_irq}
    localparam logic [21:0] VEC [9] = '{
        {6'b000001, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000001, 1'b1}, // R4 R7
        {6'b000000, 1'b0, 1'b1, 1'b1, 6'b000000, 6'b000001, 1'b0}, // R6 R7 mask off
        {6'b100100, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b100101, 1'b0}, // R4
        {6'b000000, 1'b0, 1'b1, 1'b1, 6'b000100, 6'b100101, 1'b1}, // R7 one enabled
        {6'b000000, 1'b0, 1'b1, 1'b0, 6'b111111, 6'b100101, 1'b1}, // R6 ignored
        {6'b000000, 1'b1, 1'b0, 1'b0, 6'b000000, 6'b000000, 1'b0}, // R5 clear
        {6'b000100, 1'b1, 1'b0, 1'b0, 6'b000000, 6'b000100, 1'b1}, // R5 set wins
        {6'b010000, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b010100, 1'b1}, // R4
        {6'b000000, 1'b1, 1'b0, 1'b0, 6'b000000, 6'b000000, 1'b0}  // R5
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // advance one edge; inputs settle and sampling happen away from the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        ovr_strobe = '0; stat_clr = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; idle_inputs();
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        do_reset();
        #1;
        check("R9 flag", {5'b0, flag_n}, 6'b000001);
        check("R9 irq", {5'b0, irq}, 6'b000000);
        reg_addr = 1'b0; #1;
        check("R9 status", reg_rdata, 6'b000000);
        reg_addr = 1'b1; #1;
        check("R9 mask", reg_rdata, 6'b111111);
        reg_addr = 1'b0;

        // table walk in register mode
        reg_mode = 1'b1;
        for (int k = 0; k < 9; k++) begin
            ovr_strobe = VEC[k][21:16];
            stat_clr   = VEC[k][15];
            reg_we     = VEC[k][14];
            reg_addr   = VEC[k][13];
            reg_wdata  = VEC[k][12:7];
            tick();
            idle_inputs();
            #1;
            check($sformatf("R4/R5/R6 vec%0d status", k), reg_rdata, VEC[k][6:1]);
            check($sformatf("R7 vec%0d irq", k), {5'b0, irq}, {5'b0, VEC[k][0]});
            check($sformatf("R8 vec%0d flag", k), {5'b0, flag_n}, 6'b000001);
        end
        reg_addr = 1'b1; #1;
        check("R6 mask readback", reg_rdata, 6'b000100);
        reg_addr = 1'b0;

        // R1 / R2 single strobe in stand-alone mode
        do_reset();
        reg_mode = 1'b0;
        ovr_strobe = 6'b001000; #1;
        check("R1 flag same cycle", {5'b0, flag_n}, 6'b000000);
        tick(); idle_inputs();
        for (int k = 0; k < TMO - 2; k++) tick();
        check("R2 flag low last cycle", {5'b0, flag_n}, 6'b000000);
        check("R8 irq quiet standalone", {5'b0, irq}, 6'b000000);
        check("R4 status set in standalone", reg_rdata, 6'b001000);
        tick();
        check("R2 flag released", {5'b0, flag_n}, 6'b000001);

        // R3 retrigger mid-window
        ovr_strobe = 6'b000001; tick(); idle_inputs();
        for (int k = 0; k < 5; k++) tick();
        ovr_strobe = 6'b100000; #1;
        check("R1 flag on retrigger", {5'b0, flag_n}, 6'b000000);
        tick(); idle_inputs();
        for (int k = 0; k < TMO - 2; k++) tick();
        check("R3 still low after restart", {5'b0, flag_n}, 6'b000000);
        tick();
        check("R3 release from newest strobe", {5'b0, flag_n}, 6'b000001);

        // R8 register mode during hold, then back
        ovr_strobe = 6'b000010; tick(); idle_inputs();
        tick();
        check("R8 held low before switch", {5'b0, flag_n}, 6'b000000);
        reg_mode = 1'b1; #1;
        check("R8 flag high in reg mode", {5'b0, flag_n}, 6'b000001);
        ovr_strobe = 6'b000100; #1;
        check("R8 strobe in reg mode flag", {5'b0, flag_n}, 6'b000001);
        tick(); idle_inputs();
        check("R7 irq in reg mode", {5'b0, irq}, 6'b000001);
        reg_mode = 1'b0; #1;
        check("R8 irq low standalone", {5'b0, irq}, 6'b000000);
        check("R8 timer abandoned", {5'b0, flag_n}, 6'b000001);

        // R9 reset mid-operation
        ovr_strobe = 6'b111111; tick(); idle_inputs();
        reg_addr = 1'b1; reg_we = 1'b1; reg_wdata = 6'b000000; tick(); idle_inputs();
        rst = 1'b1; tick(); rst = 1'b0;
        check("R9 flag after reset", {5'b0, flag_n}, 6'b000001);
        check("R9 status after reset", reg_rdata, 6'b000000);
        reg_addr = 1'b1; #1;
        check("R9 mask after reset", reg_rdata, 6'b111111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule